// File: doc/BRIEF.md
# Divide-by-7/8 Dual-Modulus Prescaler

This block sits directly on a high-speed clock and produces a slower clock whose period is either eight or seven input cycles. A separate channel-selecting counter, clocked by the divided output, drives the modulus select. A 0 on that select gives a period of eight input cycles, and a 1 gives seven. Over one full loop the counter mixes the two ratios to reach any overall division it needs.

Inside, a two-flop core counts in fours or threes. A toggle stage after the core halves the core's rate. Together the three state flops walk through up to eight states, numbered by the core count in the low bits and the toggle flop as the high bit.

In the seven-cycle mode the core ends its loop one state early, but only while the toggle flop is high. This drops state 7 (core count 3 with the toggle high). As a result only the output's high phase is shortened.

The select is sampled once per output period, on the edge that wraps the state back to 0. That sampled value sets the length of the period that starts on the same edge. A select change in the middle of a period therefore cannot give a period that is neither seven nor eight cycles long.

Top module: `dualModPrescaler`

## Requirements
- R1: While `rst` is high at a rising edge of `clkIn`, the state clears to 0 and `divOut` is 0 from the next edge on.
- R2: With the sampled modulus at 0, the state steps 0,1,...,7,0 and the distance between consecutive rising edges of `divOut` is 8 `clkIn` cycles.
- R3: With the sampled modulus at 1, state 7 (core count 3 with the toggle flop high) is skipped: the state steps 0,...,6,0 and the distance between consecutive rising edges of `divOut` is 7 cycles.
- R4: `modSel` is sampled only on the edge where the state wraps to 0. Changes of `modSel` on any other edge have no effect on the current period.
- R5: Each period between rising edges of `divOut` is 7 or 8 cycles, equal to the `modSel` value sampled at the wrap that opened it, under arbitrary `modSel` sequences.
- R6: `divOut` is high exactly in states 4 to 7. That gives 4 high cycles out of 8, or 3 high cycles out of 7.
- R7: The sampled modulus resets to 0, so the first period after reset is 8 cycles whatever `modSel` is.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clkIn | input | 1 | High-speed input clock |
| rst | input | 1 | Synchronous active-high reset |
| modSel | input | 1 | Modulus select: 0 gives divide-by-8, 1 gives divide-by-7 |
| divOut | output | 1 | Divided clock output (toggle flop) |

## Verification
The block has no parameters that change its behaviour, so the bench builds it with the fixed two-bit core and the single toggle stage. That one build reaches every state. It covers both loop lengths, back-to-back alternation of the modulus, and select pulses that come and go in the middle of a period. It also covers a long pseudo-random modulus run in which every measured period is compared against the period length the bench predicts.

// File: rtl/pscPkg.sv
package pscPkg;
  localparam int CORE_W    = 2;
  localparam int CORE_LAST = (1 << CORE_W) - 1;
  localparam int CORE_SKIP = CORE_LAST - 1;

  typedef struct packed {
    logic coreClr;
    logic halfTog;
    logic modeLoad;
  } pscStrobe_t;
endpackage

// File: rtl/pscControl.sv
module pscControl
  import pscPkg::*;
(
  input  logic              clkIn,
  input  logic              rst,
  input  logic [CORE_W-1:0] coreCnt,
  input  logic              halfQ,
  input  logic              modeQ,
  output pscStrobe_t        strobe
);
  logic endFull;
  logic endShort;
  logic coreEnd;

  always_comb begin
    endFull  = (coreCnt == CORE_W'(CORE_LAST));
    endShort = modeQ && halfQ && (coreCnt == CORE_W'(CORE_SKIP));
    coreEnd  = endFull || endShort;
    strobe.coreClr  = coreEnd;
    strobe.halfTog  = coreEnd;
    strobe.modeLoad = coreEnd && halfQ;
  end

  // the state with core count 3 and the toggle flop high never appears in short mode
  AST_NO_STATE7: assert property (@(posedge clkIn) disable iff (rst)
    (modeQ && halfQ) |-> (coreCnt != CORE_W'(CORE_LAST))) else $error("state 7 reached"); // R3

  // the sampled modulus is loaded only at the wrap edge
  AST_MODE_HOLD: assert property (@(posedge clkIn) disable iff (rst)
    !(coreEnd && halfQ) |=> $stable(modeQ)) else $error("mode changed mid period"); // R4
endmodule

// File: rtl/pscDatapath.sv
module pscDatapath
  import pscPkg::*;
(
  input  logic              clkIn,
  input  logic              rst,
  input  logic              modSel,
  input  pscStrobe_t        strobe,
  output logic [CORE_W-1:0] coreCnt,
  output logic              halfQ,
  output logic              modeQ
);
  always_ff @(posedge clkIn) begin
    if (rst) begin
      coreCnt <= '0;
      halfQ   <= 1'b0;
      modeQ   <= 1'b0;
    end else begin
      coreCnt <= strobe.coreClr ? '0 : coreCnt + 1'b1;
      if (strobe.halfTog)  halfQ <= ~halfQ;
      if (strobe.modeLoad) modeQ <= modSel;
    end
  end

  AST_RESET_CLEAR: assert property (@(posedge clkIn)
    rst |=> (coreCnt == '0 && !halfQ && !modeQ)) else $error("reset state"); // R1

  AST_CORE_STEP: assert property (@(posedge clkIn) disable iff (rst)
    ##1 ((coreCnt == $past(coreCnt) + 1'b1) || (coreCnt == '0))) else $error("core step"); // R2

  AST_HALF_AT_END: assert property (@(posedge clkIn) disable iff (rst)
    (coreCnt != '0) |-> $stable(halfQ)) else $error("toggle outside core end"); // R6
endmodule

// File: rtl/dualModPrescaler.sv
module dualModPrescaler
  import pscPkg::*;
(
  input  logic clkIn,
  input  logic rst,
  input  logic modSel,
  output logic divOut
);
  pscStrobe_t        strobe;
  logic [CORE_W-1:0] coreCnt;
  logic              halfQ;
  logic              modeQ;

  pscControl ctrl_i (
    .clkIn  (clkIn),
    .rst    (rst),
    .coreCnt(coreCnt),
    .halfQ  (halfQ),
    .modeQ  (modeQ),
    .strobe (strobe)
  );

  pscDatapath dp_i (
    .clkIn  (clkIn),
    .rst    (rst),
    .modSel (modSel),
    .strobe (strobe),
    .coreCnt(coreCnt),
    .halfQ  (halfQ),
    .modeQ  (modeQ)
  );

  assign divOut = halfQ;
endmodule

// File: tb/dualModPrescaler_tb.sv
module dualModPrescaler_tb_top;
  logic clkIn = 1'b0;
  logic rst = 1'b1;
  logic modSel = 1'b0;
  logic divOut;

  int checks = 0;
  int errors = 0;
  int cycles = 0;
  string curReq = "R1";

  // behavioural reference
  int pos = 0;
  int lenCur = 8;
  int expOut = 0;
  int edgeCnt = 0;
  int lenAtRise = 0;
  bit haveRise = 0;
  bit prevOut = 0;

  dualModPrescaler dut_i (.clkIn(clkIn), .rst(rst), .modSel(modSel), .divOut(divOut));

  always #2.5 clkIn = ~clkIn;

  always @(posedge clkIn) begin
    cycles++;
    if (rst) begin
      pos = 0;
      lenCur = 8;
    end else if (pos == lenCur - 1) begin
      pos = 0;
      lenCur = modSel ? 7 : 8;
    end else begin
      pos++;
    end
    expOut = (pos >= 4) ? 1 : 0;
  end

  always @(negedge clkIn) begin
    checks++;
    if (divOut !== expOut[0]) begin
      errors++;
      $display("FAIL %s: divOut actual %0b expected %0d (pos %0d)", curReq, divOut, expOut, pos);
    end
    edgeCnt++;
    if (rst) begin
      haveRise = 0;
    end else if (divOut && !prevOut) begin
      if (haveRise) begin
        checks++;
        if (edgeCnt != lenAtRise || (edgeCnt != 7 && edgeCnt != 8)) begin
          errors++;
          $display("FAIL R5/%s: period actual %0d expected %0d", curReq, edgeCnt, lenAtRise);
        end
      end
      haveRise = 1;
      lenAtRise = lenCur;
      edgeCnt = 0;
    end
    prevOut = divOut;
  end

  task automatic waitCyc(input int n);
    for (int i = 0; i < n; i++) begin
      @(posedge clkIn);
      #1;
    end
  endtask

  initial begin : watchdog
    wait (cycles > 100000);
    errors++;
    $display("FAIL watchdog: cycles actual %0d expected below 100000", cycles);
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin : stim
    logic [15:0] lfsr;
    curReq = "R1";
    modSel = 1'b1;
    waitCyc(4);
    rst = 1'b0;
    curReq = "R7";            // first period is 8 with modSel held at 1
    waitCyc(9);
    curReq = "R3";            // divide by 7, state 7 skipped
    waitCyc(60);
    modSel = 1'b0;
    curReq = "R2";            // divide by 8
    waitCyc(70);
    curReq = "R6";            // duty: checked every cycle by the model
    waitCyc(30);
    curReq = "R4";            // short select pulses inside a period
    for (int k = 0; k < 40; k++) begin
      modSel = 1'b1;
      waitCyc(1 + (k % 3));
      modSel = 1'b0;
      waitCyc(2 + (k % 5));
    end
    curReq = "R5";            // alternation and pseudo-random select
    for (int k = 0; k < 30; k++) begin
      modSel = k[0];
      waitCyc(8);
    end
    lfsr = 16'hACE1;
    for (int k = 0; k < 3000; k++) begin
      lfsr = {lfsr[14:0], lfsr[15] ^ lfsr[13] ^ lfsr[12] ^ lfsr[10]};
      modSel = lfsr[0];
      waitCyc(1);
    end
    curReq = "R1";
    rst = 1'b1;
    waitCyc(3);
    rst = 1'b0;
    curReq = "R7";
    modSel = 1'b1;
    waitCyc(20);
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule